// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which analog input a converter samples next and when it does so. Software writes a channel bitmask, a walk direction, a run mode, a trigger edge selection and a group size through a small write-only register port. An external trigger line is edge-detected, and each accepted trigger starts one or more conversions. For each conversion the sequencer raises a request carrying a channel index and holds it until the converter returns a done strobe with its sample. It forwards every sample together with its channel tag and raises a sticky end-of-pass flag once the last enabled channel of the list has been converted.

Enabled channels are always visited in channel-number order, upward or downward. Four run modes cover the usual needs: one channel per trigger, one full pass per trigger, endless passes after one trigger, and fixed-size groups per trigger. Rewriting the mask abandons any conversion in flight and sends the walk back to the start of the list.

Top module: `adc_seq_ctrl`

Register port (`reg_addr`): 0 writes the channel mask (bit n enables channel n). 1 writes control: bit 0 direction (0 upward, 1 downward), bits 2:1 mode (0 one-per-trigger, 1 single pass, 2 endless, 3 grouped), bits 4:3 edge select (0 off, 1 rising, 2 falling, 3 both), bits 8:5 group size minus one. 2 writes the interrupt enable in bit 0. 3 is the status port: writing bit 0 as 1 clears the end-of-pass flag.

## Requirements
- R1: After reset no request, no result, the end-of-pass flag and the interrupt are all low.
- R2: With direction 0 the enabled channels are converted from the lowest number to the highest, and every requested channel is enabled in the mask.
- R3: With direction 1 the enabled channels are converted from the highest number to the lowest.
- R4: In mode 0 each trigger converts exactly one channel and advances to the next enabled channel; after the last channel the end-of-pass flag sets and the next trigger starts again at the first channel.
- R5: In mode 1 a single trigger converts every enabled channel once, back to back, then sets the end-of-pass flag and stops.
- R6: In mode 2 a single trigger starts passes over the list that repeat without end, setting the end-of-pass flag at the end of each pass.
- R7: In mode 3 each trigger converts the next (group field + 1) enabled channels, or fewer when the list end comes first; at the list end the end-of-pass flag sets and the following trigger starts at the first channel.
- R8: Edge select 0 ignores the trigger line; 1 starts on a rising edge only, 2 on a falling edge only, 3 on either edge.
- R9: Writing the mask drops any request from the next cycle on, no further results follow, and the next trigger starts at the first channel of the list.
- R10: The end-of-pass flag stays set until 1 is written to status bit 0 (writing 0 leaves it); the interrupt output is the flag gated by the interrupt enable.
- R11: With an all-zero mask no conversion starts, and a trigger seen then is dropped, not kept for later.
- R12: A trigger that arrives while a conversion or group is running is ignored, and the requested channel holds steady until done.
- R13: Each result is output with a valid strobe, the channel tag and the converter sample in the same cycle as the converter's done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| trig_in | input | 1 | External trigger line |
| conv_req | output | 1 | Conversion request, held until done |
| conv_ch | output | 5 | Channel to convert |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | DATA_W | Converter sample, valid with done |
| res_valid | output | 1 | Result strobe |
| res_ch | output | 5 | Channel tag of the result |
| res_data | output | DATA_W | Result sample |
| eos_flag | output | 1 | Sticky end-of-pass flag |
| eos_irq | output | 1 | End-of-pass interrupt |

## Verification
The bench builds the sequencer with NUM_CH = 6, DATA_W = 12 and GRP_W = 4, driven by a converter model with a fixed three-cycle latency. Six channels make every one of the 63 non-empty masks reachable in both walk directions, so channel order, pass length and the end-of-pass flag are compared against orders computed in the bench for the whole mask space. Group sizes 1 to 4 over a five-channel list reach both the even split and the short final group, and the edge-select sweep covers all four encodings with separate rising and falling edges.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int TAG_W = 5;

  typedef enum logic [1:0] {
    MODE_STEP  = 2'd0,
    MODE_PASS  = 2'd1,
    MODE_LOOP  = 2'd2,
    MODE_GROUP = 2'd3
  } seq_mode_e;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_DIR = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_POL_LSB = 3;
  localparam int CTRL_GRP_LSB = 5;

  typedef struct packed {
    logic             hit;
    logic [TAG_W-1:0] ch;
  } pick_t;

  // Find the first enabled channel in walk order; when from_start is low,
  // only channels strictly past cur (in walk order) qualify.
  function automatic pick_t pick_ch(input logic [31:0] m, input logic down,
                                    input logic from_start,
                                    input logic [TAG_W-1:0] cur);
    pick_t r;
    r.hit = 1'b0;
    r.ch  = '0;
    for (int k = 0; k < 32; k++) begin
      int i;
      i = down ? (31 - k) : k;
      if (!r.hit && m[i] &&
          (from_start || (down ? (i < int'(cur)) : (i > int'(cur))))) begin
        r.hit = 1'b1;
        r.ch  = TAG_W'(i);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic [1:0] pol,
  output logic       fire
);
  logic prev_q;
  logic edge_up;
  logic edge_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= trig_in;
  end

  assign edge_up = trig_in & ~prev_q;
  assign edge_dn = ~trig_in & prev_q;
  assign fire    = (pol[0] & edge_up) | (pol[1] & edge_dn);

endmodule

// File: rtl/adc_seq_walk.sv
module adc_seq_walk
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 19
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic              down,
  input  logic [TAG_W-1:0]  cur,
  output logic              first_hit,
  output logic [TAG_W-1:0]  first_ch,
  output logic              next_hit,
  output logic [TAG_W-1:0]  next_ch
);
  logic [31:0] mask_ext;
  pick_t       p_first;
  pick_t       p_next;

  assign mask_ext  = 32'(mask);
  assign p_first   = pick_ch(mask_ext, down, 1'b1, cur);
  assign p_next    = pick_ch(mask_ext, down, 1'b0, cur);
  assign first_hit = p_first.hit;
  assign first_ch  = p_first.ch;
  assign next_hit  = p_next.hit;
  assign next_ch   = p_next.ch;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 19,
  parameter int DATA_W = 12,
  parameter int GRP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              trig_in,
  output logic              conv_req,
  output logic [TAG_W-1:0]  conv_ch,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_ch,
  output logic [DATA_W-1:0] res_data,
  output logic              eos_flag,
  output logic              eos_irq
);
  localparam int GRP_HI = CTRL_GRP_LSB + GRP_W - 1;

  logic [NUM_CH-1:0] mask_q;
  logic              dir_q;
  seq_mode_e         mode_q;
  logic [1:0]        pol_q;
  logic [GRP_W-1:0]  grp_last_q;
  logic              ien_q;
  logic              busy_q;
  logic              at_start_q;
  logic [TAG_W-1:0]  cur_q;
  logic [TAG_W-1:0]  ptr_q;
  logic [GRP_W-1:0]  grp_cnt_q;
  logic              flag_q;

  logic              mask_wr;
  logic              ctrl_wr;
  logic              ien_wr;
  logic              flag_clr;
  logic              fire;
  logic              first_hit;
  logic              next_hit;
  logic [TAG_W-1:0]  first_ch;
  logic [TAG_W-1:0]  next_ch;
  logic              accept_trig;
  logic              step_done;
  logic              eos_set;
  logic              group_full;
  logic [31:0]       mask_ext;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign mask_wr  = reg_we && (reg_addr == ADDR_MASK);
  assign ctrl_wr  = reg_we && (reg_addr == ADDR_CTRL);
  assign ien_wr   = reg_we && (reg_addr == ADDR_IEN);
  assign flag_clr = reg_we && (reg_addr == ADDR_STAT) && reg_wdata[0];

  adc_seq_trig u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .pol     (pol_q),
    .fire    (fire)
  );

  adc_seq_walk #(.NUM_CH(NUM_CH)) u_walk (
    .mask      (mask_q),
    .down      (dir_q),
    .cur       (cur_q),
    .first_hit (first_hit),
    .first_ch  (first_ch),
    .next_hit  (next_hit),
    .next_ch   (next_ch)
  );

  assign accept_trig = !busy_q && !mask_wr && fire && first_hit;
  assign step_done   = busy_q && conv_done && !mask_wr;
  assign eos_set     = step_done && !next_hit;
  assign group_full  = (grp_cnt_q == grp_last_q);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      dir_q      <= 1'b0;
      mode_q     <= MODE_STEP;
      pol_q      <= 2'd0;
      grp_last_q <= '0;
      ien_q      <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= reg_wdata[NUM_CH-1:0];
      if (ctrl_wr) begin
        dir_q      <= reg_wdata[CTRL_DIR];
        mode_q     <= seq_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
        pol_q      <= reg_wdata[CTRL_POL_LSB +: 2];
        grp_last_q <= reg_wdata[GRP_HI:CTRL_GRP_LSB];
      end
      if (ien_wr) ien_q <= reg_wdata[0];
    end
  end

  // walk state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      at_start_q <= 1'b1;
      cur_q      <= '0;
      ptr_q      <= '0;
      grp_cnt_q  <= '0;
    end else if (mask_wr) begin
      busy_q     <= 1'b0;
      at_start_q <= 1'b1;
      grp_cnt_q  <= '0;
    end else if (accept_trig) begin
      busy_q    <= 1'b1;
      cur_q     <= at_start_q ? first_ch : ptr_q;
      grp_cnt_q <= '0;
    end else if (step_done) begin
      grp_cnt_q <= grp_cnt_q + 1'b1;
      if (next_hit) begin
        ptr_q      <= next_ch;
        at_start_q <= 1'b0;
      end else begin
        at_start_q <= 1'b1;
      end
      unique case (mode_q)
        MODE_STEP: busy_q <= 1'b0;
        MODE_PASS: begin
          if (!next_hit) busy_q <= 1'b0;
          else           cur_q  <= next_ch;
        end
        MODE_LOOP: cur_q <= next_hit ? next_ch : first_ch;
        MODE_GROUP: begin
          if (!next_hit || group_full) busy_q <= 1'b0;
          else                         cur_q  <= next_ch;
        end
        default: busy_q <= 1'b0;
      endcase
    end
  end

  // sticky end-of-pass flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (eos_set)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign conv_req  = busy_q;
  assign conv_ch   = cur_q;
  assign res_valid = busy_q && conv_done;
  assign res_ch    = cur_q;
  assign res_data  = conv_data;
  assign eos_flag  = flag_q;
  assign eos_irq   = flag_q && ien_q;

  assign mask_ext = 32'(mask_q);

  AST_CH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> mask_ext[conv_ch]); // R2
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !conv_req); // R11
  AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !mask_wr) |=> (conv_req && $stable(conv_ch))); // R12
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !conv_req); // R9
  AST_EOS_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_flag) |-> $past(res_valid)); // R10
  AST_POL_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_req && pol_q == 2'd0) |=> !conv_req); // R8

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int NCH = 6;
  localparam int DW  = 12;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          trig_in = 1'b0;
  logic          conv_req;
  logic [4:0]    conv_ch;
  logic          conv_done;
  logic [DW-1:0] conv_data;
  logic          res_valid;
  logic [4:0]    res_ch;
  logic [DW-1:0] res_data;
  logic          eos_flag;
  logic          eos_irq;

  int errors = 0;
  int checks = 0;
  int log_ch [0:63];
  int log_n = 0;
  int rcnt = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .GRP_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .trig_in(trig_in), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .eos_flag(eos_flag), .eos_irq(eos_irq)
  );

  function automatic logic [DW-1:0] sample_of(input int ch);
    return DW'(ch * 37 + 5);
  endfunction

  // fixed-latency converter model
  always @(posedge clk) begin
    if (!rst_n || !conv_req || conv_done) rcnt <= 0;
    else rcnt <= rcnt + 1;
  end
  assign conv_done = conv_req && (rcnt == LAT - 1);
  assign conv_data = sample_of(int'(conv_ch));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result monitor, R13: sample travels with its tag in the done cycle
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (log_n < 64) log_ch[log_n] = int'(res_ch);
      log_n++;
      chk(res_data == sample_of(int'(res_ch)) && conv_done, "R13 data",
          int'(res_data), int'(sample_of(int'(res_ch))));
    end
  end

  function automatic int popc(input int m);
    int c = 0;
    for (int i = 0; i < NCH; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int exp_at(input int m, input bit down, input int k);
    int c = 0;
    for (int kk = 0; kk < NCH; kk++) begin
      int i;
      i = down ? (NCH - 1 - kk) : kk;
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  function automatic logic [31:0] ctrl_word(input bit down, input int mode,
                                            input int pol, input int gsz);
    return 32'(down) | 32'(mode << 1) | 32'(pol << 3) | 32'((gsz - 1) << 5);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (conv_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ok;
    int n;
    int pos;
    int take;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!conv_req && !res_valid, "R1 idle", int'(conv_req), 0);
    chk(!eos_flag && !eos_irq, "R1 flags", int'(eos_flag), 0);

    // R2, R3, R5: single pass over every mask in both directions
    for (int d = 0; d < 2; d++) begin
      wr(2'd1, ctrl_word(d[0], 1, 1, 1));
      for (int m = 1; m < (1 << NCH); m++) begin
        wr(2'd0, 32'(m));
        log_n = 0;
        pulse();
        wait_idle();
        n = popc(m);
        ok = (log_n == n);
        for (int k = 0; k < n; k++) if (log_ch[k] != exp_at(m, d[0], k)) ok = 0;
        if (d == 0) chk(ok != 0, "R2 ascending pass", log_n, n);
        else        chk(ok != 0, "R3 descending pass", log_n, n);
        chk(eos_flag == 1'b1, "R5 eos after pass", int'(eos_flag), 1);
        wr(2'd3, 32'd1);
      end
    end

    // R10: flag, enable gating and write-1-to-clear
    wr(2'd0, 32'h3);
    log_n = 0;
    pulse();
    wait_idle();
    wr(2'd2, 32'd0);
    chk(eos_flag && !eos_irq, "R10 irq gated off", int'(eos_irq), 0);
    wr(2'd2, 32'd1);
    chk(eos_irq == 1'b1, "R10 irq on", int'(eos_irq), 1);
    wr(2'd3, 32'd0);
    chk(eos_flag == 1'b1, "R10 write 0 keeps flag", int'(eos_flag), 1);
    wr(2'd3, 32'd1);
    chk(!eos_flag && !eos_irq, "R10 cleared", int'(eos_flag), 0);

    // R4: one channel per trigger with wrap
    wr(2'd1, ctrl_word(1'b0, 0, 1, 1));
    wr(2'd0, 32'h2D);
    log_n = 0;
    for (int t = 0; t < 8; t++) begin
      pulse();
      wait_idle();
      chk(log_n == t + 1 && log_ch[t] == exp_at(32'h2D, 1'b0, t % 4),
          "R4 step channel", log_ch[t], exp_at(32'h2D, 1'b0, t % 4));
      chk(eos_flag == ((t % 4) == 3), "R4 eos at list end",
          int'(eos_flag), int'((t % 4) == 3));
      wr(2'd3, 32'd1);
    end

    // R7: grouped, sizes 1..4 over five channels, downward
    for (int g = 1; g <= 4; g++) begin
      wr(2'd1, ctrl_word(1'b1, 3, 1, g));
      wr(2'd0, 32'h3B);
      log_n = 0;
      pos = 0;
      for (int t = 0; t < 6; t++) begin
        base = log_n;
        pulse();
        wait_idle();
        take = (g < 5 - pos) ? g : (5 - pos);
        ok = (log_n - base == take);
        for (int k = 0; k < take; k++)
          if (log_ch[base + k] != exp_at(32'h3B, 1'b1, pos + k)) ok = 0;
        chk(ok != 0, "R7 group content", log_n - base, take);
        chk(eos_flag == (pos + take == 5), "R7 eos at end",
            int'(eos_flag), int'(pos + take == 5));
        pos = (pos + take) % 5;
        wr(2'd3, 32'd1);
      end
    end

    // R6 and R9: endless passes, then abort by mask write
    wr(2'd1, ctrl_word(1'b1, 2, 1, 1));
    wr(2'd0, 32'h6);
    log_n = 0;
    pulse();
    while (log_n < 7) @(negedge clk);
    ok = 1;
    for (int k = 0; k < 7; k++) if (log_ch[k] != exp_at(32'h6, 1'b1, k % 2)) ok = 0;
    chk(ok != 0, "R6 repeating order", log_ch[2], exp_at(32'h6, 1'b1, 0));
    chk(eos_flag == 1'b1, "R6 eos per pass", int'(eos_flag), 1);
    wr(2'd0, 32'h6);
    chk(conv_req == 1'b0, "R9 request dropped", int'(conv_req), 0);
    n = log_n;
    repeat (20) @(negedge clk);
    chk(log_n == n, "R9 no results after abort", log_n, n);
    wr(2'd3, 32'd1);

    // R9: pointer returns to first channel after mask rewrite
    wr(2'd1, ctrl_word(1'b0, 0, 1, 1));
    wr(2'd0, 32'h1C);
    log_n = 0;
    pulse(); wait_idle();
    pulse(); wait_idle();
    wr(2'd0, 32'h1C);
    pulse(); wait_idle();
    chk(log_n == 3 && log_ch[2] == 2, "R9 restart at first", log_ch[2], 2);

    // R8: edge select sweep, one channel
    wr(2'd0, 32'h4);
    for (int p = 0; p < 4; p++) begin
      wr(2'd1, ctrl_word(1'b0, 0, p, 1));
      log_n = 0;
      @(negedge clk); trig_in = 1'b1;
      repeat (8) @(negedge clk);
      n = log_n;
      chk(n == (p & 1), "R8 rising edge", n, p & 1);
      trig_in = 1'b0;
      repeat (8) @(negedge clk);
      chk(log_n - n == ((p >> 1) & 1), "R8 falling edge", log_n - n, (p >> 1) & 1);
    end
    wr(2'd3, 32'd1);

    // R11: empty mask drops triggers
    wr(2'd1, ctrl_word(1'b0, 0, 1, 1));
    wr(2'd0, 32'h0);
    log_n = 0;
    pulse();
    repeat (6) @(negedge clk);
    chk(log_n == 0 && !conv_req, "R11 no start on empty", log_n, 0);
    wr(2'd0, 32'h1);
    repeat (6) @(negedge clk);
    chk(log_n == 0 && !conv_req, "R11 trigger not kept", log_n, 0);

    // R12: triggers during a pass are ignored
    wr(2'd1, ctrl_word(1'b0, 1, 1, 1));
    wr(2'd0, 32'h7);
    log_n = 0;
    pulse();
    pulse();
    pulse();
    wait_idle();
    repeat (10) @(negedge clk);
    chk(log_n == 3, "R12 busy trigger ignored", log_n, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule